// File: doc/BRIEF.md
# Pulsed and Continuous Chirp Generator

This block produces a complex baseband linear-FM waveform. A second-order phase accumulator does the work. Its frequency word grows by a fixed step on every active cycle, and the phase word adds that frequency word on every cycle. A pulse-timing state machine gates the accumulator and controls when the output is active.

Software computes and writes the start increment, the step, the pulse length, the repetition interval, the pulse count and the mode. It then raises a start bit, and the block runs the burst on its own. There are three modes:

- **Pulsed chirp:** a train of pulses.
- **Tone:** a steady single frequency with the step ignored.
- **Sweep:** a repeating chirp. The active flag drops for exactly one cycle at the end of each period, and the accumulator restarts after that cycle.

A sine/cosine table holds one full wave. The top bits of the phase word address it, and it returns signed I and Q.

Top module: `lfm_burst_gen`

## Requirements
- R1: While reset is asserted and after its release with no launch, tx_active is 0 and phase_out, i_out and q_out are all zero.
- R2: A burst launches only on a 0-to-1 transition of start_req seen while idle. The first active cycle is the one right after the edge that sees the transition. All settings are captured at launch; input changes, and toggling of start_req, during a pulsed burst have no effect on it.
- R3: The mode codes are: 0 or 3 = pulsed, 1 = tone, 2 = sweep. In pulsed mode, cycle j of the burst has c = j mod pri_len and p = j / pri_len. tx_active is 1 when c < pulse_len and p < max(pulse_num,1), and 0 otherwise. This requires pri_len >= 1.
- R4: Each pulse or chirp period starts with phase index k = 0. While active, phase_out = k*inc_start + inc_step*k*(k-1)/2 mod 2^32, where k counts the active cycles since that start. phase_out is 0 whenever tx_active is 0. A pulse that follows another with no gap still restarts.
- R5: In tone mode, tx_active stays 1 from launch, and phase_out = k*inc_start for k counted from launch; inc_step is ignored.
- R6: In sweep mode, with c = j mod pulse_len, tx_active is 0 only when c = pulse_len-1. The next cycle restarts with k = 0. This requires pulse_len >= 2.
- R7: After the last pulse, the block waits with tx_active 0 until start_req reads 0, then becomes idle. In tone and sweep modes, a 0 on start_req ends the burst, and tx_active is 0 from the next cycle.
- R8: i_out and q_out follow phase_out by one clock. For phase_out bits [31:24] = 0, 64, 128 or 192, (i_out, q_out) is (32767,0), (0,32767), (-32767,0) or (0,-32767) respectively. Both outputs are 0 in the cycle after a cycle with tx_active 0.
- R9: Both accumulators wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Start bit; 0-to-1 launches a burst |
| mode_sel | input | 2 | 0/3 pulsed, 1 tone, 2 sweep |
| inc_start | input | 32 | Frequency word at each restart |
| inc_step | input | 32 | Per-cycle frequency word step |
| pulse_len | input | 16 | Pulse length, or sweep period, in cycles |
| pri_len | input | 16 | Pulse repetition interval in cycles |
| pulse_num | input | 16 | Pulses per burst (0 acts as 1) |
| tx_active | output | 1 | Output-active flag |
| phase_out | output | 32 | Phase word, zero when inactive |
| i_out | output | 16 | In-phase sample, signed |
| q_out | output | 16 | Quadrature sample, signed |

## Verification
The end of one pulse and the start of the next can fall in the same cycle. This happens when pulse_len equals pri_len, so tx_active never drops, yet the accumulator must still restart.

The bench provokes this with back-to-back quarter-turn pulses. It checks that the phase index returns to zero at the boundary, and that the I/Q values pass through all four table corners in each pulse.

In sweep mode, the single low cycle and the restart that follows it form a similar pair. The bench judges this pair by the exact phase sequence across several periods.

// File: rtl/lfm_gen_pkg.sv
package lfm_gen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } tstate_e;

    typedef enum logic [1:0] {
        MD_PULSE = 2'd0,
        MD_TONE  = 2'd1,
        MD_SWEEP = 2'd2,
        MD_RSVD  = 2'd3
    } mode_e;
endpackage

// File: rtl/lfm_pulse_timer.sv
module lfm_pulse_timer
    import lfm_gen_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [1:0]       mode_sel,
    input  logic [ACC_W-1:0] inc_start,
    input  logic [ACC_W-1:0] inc_step,
    input  logic [CNT_W-1:0] pulse_len,
    input  logic [CNT_W-1:0] pri_len,
    input  logic [CNT_W-1:0] pulse_num,
    output logic             tx_active,
    output logic             restart,
    output logic [ACC_W-1:0] s_inc_o,
    output logic [ACC_W-1:0] d_inc_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        tstate_e          st;
        logic             start_prev;
        mode_e            mode;
        logic [ACC_W-1:0] s_inc;
        logic [ACC_W-1:0] d_inc;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] pri;
        logic [CNT_W-1:0] num;
        logic [CNT_W-1:0] cyc;
        logic [CNT_W-1:0] pulses;
    } tmr_t;

    tmr_t tm_q, tm_d;
    logic launch;
    logic running;
    logic pri_end;
    logic per_end;
    logic last_pulse;

    always_comb begin
        launch     = start_req && !tm_q.start_prev;
        running    = (tm_q.st == ST_RUN);
        pri_end    = (tm_q.cyc == tm_q.pri - ONE);
        per_end    = (tm_q.cyc == tm_q.len - ONE);
        last_pulse = ((tm_q.pulses + ONE) >= tm_q.num);

        tx_active = 1'b0;
        restart   = 1'b0;
        if (running) begin
            unique case (tm_q.mode)
                MD_TONE: begin
                    tx_active = 1'b1;
                    restart   = (tm_q.cyc == '0);
                end
                MD_SWEEP: begin
                    tx_active = !per_end;
                    restart   = !per_end && (tm_q.cyc == '0);
                end
                default: begin
                    tx_active = (tm_q.cyc < tm_q.len);
                    restart   = (tm_q.cyc < tm_q.len) && (tm_q.cyc == '0);
                end
            endcase
        end

        tm_d            = tm_q;
        tm_d.start_prev = start_req;
        unique case (tm_q.st)
            ST_IDLE: begin
                if (launch) begin
                    tm_d.st     = ST_RUN;
                    tm_d.mode   = mode_e'(mode_sel);
                    tm_d.s_inc  = inc_start;
                    tm_d.d_inc  = (mode_e'(mode_sel) == MD_TONE) ? '0 : inc_step;
                    tm_d.len    = pulse_len;
                    tm_d.pri    = pri_len;
                    tm_d.num    = pulse_num;
                    tm_d.cyc    = '0;
                    tm_d.pulses = '0;
                end
            end
            ST_RUN: begin
                unique case (tm_q.mode)
                    MD_TONE: begin
                        if (!start_req) tm_d.st = ST_IDLE;
                        tm_d.cyc = ONE;
                    end
                    MD_SWEEP: begin
                        if (!start_req) tm_d.st = ST_IDLE;
                        tm_d.cyc = per_end ? '0 : tm_q.cyc + ONE;
                    end
                    default: begin
                        if (pri_end) begin
                            tm_d.cyc = '0;
                            if (last_pulse) tm_d.st = ST_HOLD;
                            else            tm_d.pulses = tm_q.pulses + ONE;
                        end else begin
                            tm_d.cyc = tm_q.cyc + ONE;
                        end
                    end
                endcase
            end
            ST_HOLD: begin
                if (!start_req) tm_d.st = ST_IDLE;
            end
            default: tm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_q            <= '0;
            tm_q.start_prev <= 1'b1;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign s_inc_o = tm_q.s_inc;
    assign d_inc_o = tm_q.d_inc;

    // R7
    hold_until_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_q.st == ST_HOLD && start_req) |=> (tm_q.st == ST_HOLD));

    // R6
    single_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tm_q.mode == MD_SWEEP && !tx_active && start_req && tm_q.len > ONE)
        |=> tx_active);

    // R3
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (tm_q.mode == MD_PULSE || tm_q.mode == MD_RSVD))
        |-> ((tm_q.pulses < tm_q.num) || (tm_q.pulses == '0)));

    // R4
    rise_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> restart);
endmodule

// File: rtl/lfm_phase_accum.sv
module lfm_phase_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             restart,
    input  logic [ACC_W-1:0] s_inc,
    input  logic [ACC_W-1:0] d_inc,
    output logic [ACC_W-1:0] phase_o
);
    typedef struct packed {
        logic [ACC_W-1:0] ph;
        logic [ACC_W-1:0] inc;
    } acc_t;

    acc_t acc_q, acc_d;

    always_comb begin
        acc_d = acc_q;
        if (restart) begin
            acc_d.ph  = s_inc;
            acc_d.inc = s_inc + d_inc;
        end else if (act) begin
            acc_d.ph  = acc_q.ph + acc_q.inc;
            acc_d.inc = acc_q.inc + d_inc;
        end
        phase_o = (act && !restart) ? acc_q.ph : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R4
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (acc_q.ph == $past(s_inc)));

    // R9
    sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !restart) |=> (acc_q.inc == $past(acc_q.inc) + $past(d_inc)));
endmodule

// File: rtl/lfm_sincos.sv
module lfm_sincos #(
    parameter int ACC_W  = 32,
    parameter int ABITS  = 8,
    parameter int SAMP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     act,
    input  logic [ACC_W-1:0]         phase,
    output logic signed [SAMP_W-1:0] i_o,
    output logic signed [SAMP_W-1:0] q_o
);
    localparam int LUT_N = 1 << ABITS;
    localparam int HALF  = LUT_N / 2;
    localparam int QTR   = LUT_N / 4;
    localparam longint AMP = (longint'(1) << (SAMP_W - 1)) - 1;

    function automatic logic signed [SAMP_W-1:0] sine_val(input int idx);
        longint p, x, v;
        logic   neg;
        neg = (idx >= HALF);
        p   = neg ? longint'(idx - HALF) : longint'(idx);
        x   = p * (HALF - p);
        v   = (AMP * 16 * x) / (5 * HALF * HALF - 4 * x);
        if (neg) v = -v;
        return SAMP_W'(v);
    endfunction

    logic signed [SAMP_W-1:0] sin_tbl [LUT_N];

    for (genvar g = 0; g < LUT_N; g++) begin : g_tbl
        assign sin_tbl[g] = sine_val(g);
    end

    typedef struct packed {
        logic signed [SAMP_W-1:0] i;
        logic signed [SAMP_W-1:0] q;
    } iq_t;

    iq_t iq_q, iq_d;
    logic [ABITS-1:0] s_idx, c_idx;

    always_comb begin
        s_idx = phase[ACC_W-1 -: ABITS];
        c_idx = s_idx + ABITS'(QTR);
        iq_d  = '0;
        if (act) begin
            iq_d.i = sin_tbl[c_idx];
            iq_d.q = sin_tbl[s_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) iq_q <= '0;
        else        iq_q <= iq_d;
    end

    assign i_o = iq_q.i;
    assign q_o = iq_q.q;

    // R8
    zero_angle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && phase[ACC_W-1 -: ABITS] == '0)
        |=> (i_o == SAMP_W'(AMP) && q_o == '0));
endmodule

// File: rtl/lfm_burst_gen.sv
module lfm_burst_gen #(
    parameter int ACC_W     = 32,
    parameter int CNT_W     = 16,
    parameter int LUT_ABITS = 8,
    parameter int SAMP_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_req,
    input  logic [1:0]               mode_sel,
    input  logic [ACC_W-1:0]         inc_start,
    input  logic [ACC_W-1:0]         inc_step,
    input  logic [CNT_W-1:0]         pulse_len,
    input  logic [CNT_W-1:0]         pri_len,
    input  logic [CNT_W-1:0]         pulse_num,
    output logic                     tx_active,
    output logic [ACC_W-1:0]         phase_out,
    output logic signed [SAMP_W-1:0] i_out,
    output logic signed [SAMP_W-1:0] q_out
);
    logic             restart;
    logic [ACC_W-1:0] s_inc;
    logic [ACC_W-1:0] d_inc;

    lfm_pulse_timer #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .mode_sel  (mode_sel),
        .inc_start (inc_start),
        .inc_step  (inc_step),
        .pulse_len (pulse_len),
        .pri_len   (pri_len),
        .pulse_num (pulse_num),
        .tx_active (tx_active),
        .restart   (restart),
        .s_inc_o   (s_inc),
        .d_inc_o   (d_inc)
    );

    lfm_phase_accum #(.ACC_W(ACC_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (tx_active),
        .restart (restart),
        .s_inc   (s_inc),
        .d_inc   (d_inc),
        .phase_o (phase_out)
    );

    lfm_sincos #(.ACC_W(ACC_W), .ABITS(LUT_ABITS), .SAMP_W(SAMP_W)) u_sincos (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (tx_active),
        .phase (phase_out),
        .i_o   (i_out),
        .q_o   (q_out)
    );

    // R8
    gate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |=> (i_out == '0 && q_out == '0));
endmodule

// File: tb/lfm_burst_gen_bench.sv
module lfm_burst_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic [31:0] inc_start = '0;
    logic [31:0] inc_step = '0;
    logic [15:0] pulse_len = '0;
    logic [15:0] pri_len = '0;
    logic [15:0] pulse_num = '0;
    logic        tx_active;
    logic [31:0] phase_out;
    logic signed [15:0] i_out;
    logic signed [15:0] q_out;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lfm_burst_gen u_lfm_burst_gen (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .mode_sel(mode_sel),
        .inc_start(inc_start), .inc_step(inc_step), .pulse_len(pulse_len),
        .pri_len(pri_len), .pulse_num(pulse_num), .tx_active(tx_active),
        .phase_out(phase_out), .i_out(i_out), .q_out(q_out)
    );

    typedef struct {
        logic               act;
        logic [31:0]        ph;
        logic               chk_iq;
        logic signed [15:0] ei;
        logic signed [15:0] eq;
        int                 rq;
    } exp_t;

    exp_t sbq[$];
    logic        prev_act = 1'b0;
    logic [31:0] prev_ph = '0;

    function automatic logic [31:0] phase_of(input longint k, input logic [31:0] s, input logic [31:0] d);
        longint unsigned v;
        v = longint'(k) * longint'(s) + longint'(d) * ((k * (k - 1)) / 2);
        return v[31:0];
    endfunction

    // R8: expected I/Q from the previous cycle's phase corner, or zero after an idle cycle
    task automatic push_item(input logic act, input logic [31:0] ph, input int rq);
        exp_t e;
        e.act = act; e.ph = ph; e.rq = rq;
        e.chk_iq = 1'b1; e.ei = 0; e.eq = 0;
        if (prev_act) begin
            case (prev_ph[31:24])
                8'd0:   begin e.ei = 16'sd32767;  e.eq = 16'sd0;      end
                8'd64:  begin e.ei = 16'sd0;      e.eq = 16'sd32767;  end
                8'd128: begin e.ei = -16'sd32767; e.eq = 16'sd0;      end
                8'd192: begin e.ei = 16'sd0;      e.eq = -16'sd32767; end
                default: e.chk_iq = 1'b0;
            endcase
        end
        sbq.push_back(e);
        prev_act = act;
        prev_ph = ph;
    endtask

    // monitor: sample 1 ns after each rising edge
    initial forever begin
        @(posedge clk);
        #1;
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (tx_active !== e.act || phase_out !== e.ph) begin
                fails++;
                $display("FAIL R%0d: act/phase got %0b/%h expected %0b/%h", e.rq, tx_active, phase_out, e.act, e.ph);
            end
            if (e.chk_iq) begin
                checks++;
                if (i_out !== e.ei || q_out !== e.eq) begin
                    fails++;
                    $display("FAIL R8: iq got %0d/%0d expected %0d/%0d", i_out, q_out, e.ei, e.eq);
                end
            end
        end
    end

    // md: 0 pulsed (R3), 1 tone (R5), 2 sweep (R6); perturb exercises R2
    task automatic run_burst(input logic [1:0] md, input logic [31:0] s, input logic [31:0] d,
                             input int len, input int pri, input int cnt, input int ncyc,
                             input bit perturb, input int rq);
        int n, eff;
        @(negedge clk);
        mode_sel = md; inc_start = s; inc_step = d;
        pulse_len = 16'(len); pri_len = 16'(pri); pulse_num = 16'(cnt);
        start_req = 1'b1;
        eff = (cnt == 0) ? 1 : cnt;
        n = (md == 2'd1 || md == 2'd2) ? ncyc : eff * pri + 2;
        for (int j = 0; j < n; j++) begin
            logic a;
            longint k;
            a = 1'b0; k = 0;
            if (md == 2'd1) begin
                a = 1'b1; k = j;
            end else if (md == 2'd2) begin
                a = ((j % len) != len - 1); k = j % len;
            end else begin
                a = ((j / pri) < eff) && ((j % pri) < len); k = j % pri;
            end
            push_item(a, a ? phase_of(k, s, (md == 2'd1) ? 32'd0 : d) : 32'd0, rq);
        end
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            if (perturb && j == 3) begin
                start_req = 1'b0; inc_start = ~s; mode_sel = 2'd1; pulse_len = 16'd1;
            end
            if (perturb && j == 4) start_req = 1'b1;
        end
        // R7: release the start bit, output must go quiet next cycle
        start_req = 1'b0;
        push_item(1'b0, 32'd0, 7);
        push_item(1'b0, 32'd0, 7);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (tx_active !== 1'b0 || phase_out !== 32'd0 || i_out !== 16'sd0 || q_out !== 16'sd0) begin
            fails++;
            $display("FAIL R1: reset outputs %0b %h %0d %0d expected 0 0 0 0", tx_active, phase_out, i_out, q_out);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        checks++;
        if (tx_active !== 1'b0 || phase_out !== 32'd0) begin
            fails++;
            $display("FAIL R1: idle outputs %0b %h expected 0 0", tx_active, phase_out);
        end
        // R3 R4: pulsed chirp with gaps
        run_burst(2'd0, 32'h0100_0000, 32'h0001_0000, 5, 8, 3, 0, 1'b0, 3);
        // R4: back-to-back pulses (len == pri), quarter-turn steps hit every table corner
        run_burst(2'd0, 32'h4000_0000, 32'd0, 4, 4, 2, 0, 1'b0, 4);
        // R2: settings and start toggles during a burst ignored; pulse_num 0 acts as 1
        run_burst(2'd0, 32'h0200_0000, 32'h0003_0000, 6, 9, 0, 0, 1'b1, 2);
        // R5: tone, step ignored
        run_burst(2'd1, 32'h4000_0000, 32'h0012_3450, 1, 1, 1, 10, 1'b0, 5);
        // R6: sweep with one-cycle gap and restart
        run_burst(2'd2, 32'h1000_0000, 32'h0800_0000, 4, 1, 1, 12, 1'b0, 6);
        // R9: wrap of both accumulators; mode code 3 behaves as pulsed (R3)
        run_burst(2'd3, 32'hF000_0000, 32'h2000_0000, 6, 6, 1, 0, 1'b0, 9);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule